// File: doc/BRIEF.md
# Spread-Spectrum Frequency Offset Sweeper

This block drives the frequency control of a downstream clock synthesizer so that the recovered pixel clock wanders above and below the reference frequency instead of sitting on one tone. Running on the reference clock, it steps a phase counter through a fixed modulation period and turns each phase into a signed offset word. The word is in units of 0.01 %, so 400 means +4 % and -200 means -2 %. The profile is a symmetric triangle that starts at zero, climbs to the positive peak, falls through zero to the negative peak, and climbs back to zero.

A single select input picks a wide or a narrow sweep depth at run time. The select is synchronised into the clock domain. Every change of the synchronised level starts a long blanking interval, during which the `blank_o` output tells the datapath to hold its parallel outputs low and treat them as invalid. The new depth does not cut in mid-slope: it is adopted at the next point where the triangle passes through zero, so the offset word never jumps. A run input gates the whole sweep. While it is low the offset is zero and the phase is parked at the start of the profile.

Top module: `ssm_profile_gen`

## Requirements
- R1: After reset `freq_offset_o` is 0, `blank_o` is low and the synchronised select level starts low (narrow depth).
- R2: While `run_en_i` is low, `freq_offset_o` is 0 from the next rising edge on and the phase returns to its start. Let edge j = 0 be the first rising edge at which `run_en_i` is high. The value sampled after edge j then follows the R3 profile at phase j.
- R3: With period P = 1024 and depth D, phase p = j mod P gives the shape t(p): t = p for p < 256, t = 512 - p for 256 <= p < 768, and t = p - 1024 otherwise. The output is D*t/256, truncated toward zero, as a signed 12-bit value.
- R4: D is 400 when the synchronised select is high and 200 when it is low. The profile peaks at exactly +D at phase 256 and -D at phase 768, which lies inside the 360..440 and 180..220 windows.
- R5: `spread_wide_i` passes through two synchronising flops, and a change is detected on the synchronised level. `blank_o` rises after the third rising edge that samples the new input level.
- R6: Each detected change keeps `blank_o` high for exactly 32800 clock cycles, after which it falls. `blank_o` never rises without a detected change.
- R7: A further detected change while `blank_o` is high restarts the full 32800-cycle interval from that change.
- R8: While running, a new depth is adopted only at phase 0 or phase 512, where the offset is zero. The offset never moves by more than 2 units between consecutive cycles.
- R9: While `run_en_i` is low, a new depth is adopted at once, so the first sweep after enabling already uses it. Blanking runs regardless of `run_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_wide_i | input | 1 | Sweep depth select, high = wide (±4 %), low = narrow (±2 %); asynchronous |
| run_en_i | input | 1 | Sweep enable; low parks the phase and zeroes the offset |
| freq_offset_o | output | 12 | Signed frequency offset in units of 0.01 % |
| blank_o | output | 1 | High while the parallel data outputs must be held low after a depth change |

## Verification
Two things can contend for the same cycle. The first is a reload of the blanking counter by a second select change while the counter is still running down from the first. The second is the adoption of a pending depth at a zero crossing, which happens on the same edge that computes the crossing's own offset. The first case is provoked by toggling the select twice, 1000 cycles apart. It is judged by the total length of the blanking interval, which must be the gap between the two changes plus one full interval. The second case is provoked by changing the select in the rising quarter of a sweep. The bench then checks every sample against a model that keeps the old depth through phase 512 and applies the new one from phase 513, and it bounds the cycle-to-cycle step across the swap.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
   typedef enum logic {
      SPREAD_NARROW = 1'b0,
      SPREAD_WIDE   = 1'b1
   } spread_e;

   // offsets are expressed in hundredths of a percent
   localparam int SSM_UNITS_PER_PCT = 100;
endpackage

// File: rtl/ssm_level_sync.sv
module ssm_level_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES > 8) begin : g_bad_stages
         $error("ssm_level_sync: STAGES must be 0..8");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= (chain << 1) | STAGES'(d);
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ssm_blank_timer.sv
module ssm_blank_timer #(
   parameter int HOLD = 32800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic blank
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("ssm_blank_timer: HOLD must be at least 1");
      end
   endgenerate

   logic          prev_lvl;
   logic          load;
   logic [CW-1:0] cnt;

   assign load  = level ^ prev_lvl;
   assign blank = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b0;
         cnt      <= '0;
      end else begin
         prev_lvl <= level;
         if (load)             cnt <= HOLD_C;
         else if (cnt != '0)   cnt <= cnt - CW'(1);
      end
   end

   assert_blank_follows_change_R5 : assert property (
      @(posedge clk) disable iff (!rst_n) load |=> blank);

   assert_no_spurious_blank_R6 : assert property (
      @(posedge clk) disable iff (!rst_n) (!blank && !load) |=> !blank);

   assert_blank_ends_without_change_R7 : assert property (
      @(posedge clk) disable iff (!rst_n) $fell(blank) |-> !$past(load));
endmodule

// File: rtl/ssm_tri_profile.sv
module ssm_tri_profile #(
   parameter int PERIOD      = 1024,
   parameter int OFS_W       = 12,
   parameter int WIDE_PPTT   = 400,
   parameter int NARROW_PPTT = 200
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_en,
   input  logic                    wide_sel,
   output logic signed [OFS_W-1:0] offset
);
   localparam int PH_W    = $clog2(PERIOD);
   localparam int QUARTER = PERIOD / 4;
   localparam int PW      = OFS_W + PH_W + 2;
   localparam int STEP    = (WIDE_PPTT + QUARTER - 1) / QUARTER;

   localparam logic [PH_W-1:0]          Q1_P     = PH_W'(QUARTER);
   localparam logic [PH_W-1:0]          HALF_P   = PH_W'(2 * QUARTER);
   localparam logic [PH_W-1:0]          Q3_P     = PH_W'(3 * QUARTER);
   localparam logic signed [PH_W:0]     HALF_S   = (PH_W+1)'(2 * QUARTER);
   localparam logic signed [PH_W:0]     PERIOD_S = (PH_W+1)'(PERIOD);
   localparam logic signed [PW-1:0]     QTR_S    = PW'(QUARTER);
   localparam logic signed [OFS_W-1:0]  WIDE_S   = OFS_W'(WIDE_PPTT);
   localparam logic signed [OFS_W-1:0]  NARROW_S = OFS_W'(NARROW_PPTT);
   localparam logic signed [OFS_W-1:0]  STEP_S   = OFS_W'(STEP);

   generate
      if ((PERIOD < 8) || ((PERIOD & (PERIOD - 1)) != 0)) begin : g_bad_period
         $error("ssm_tri_profile: PERIOD must be a power of two >= 8");
      end
      if ((WIDE_PPTT >= (1 << (OFS_W - 1))) || (NARROW_PPTT > WIDE_PPTT)) begin : g_bad_depth
         $error("ssm_tri_profile: depths must fit OFS_W and NARROW <= WIDE");
      end
   endgenerate

   logic [PH_W-1:0]          phase;
   logic signed [OFS_W-1:0]  active_depth;
   logic signed [OFS_W-1:0]  pending_depth;
   logic signed [PH_W:0]     shape;
   logic signed [PW-1:0]     product;
   logic signed [OFS_W-1:0]  scaled;
   logic                     at_zero;

   assign pending_depth = wide_sel ? WIDE_S : NARROW_S;
   assign at_zero       = (phase == '0) || (phase == HALF_P);

   always_comb begin
      if (phase < Q1_P)      shape = $signed({1'b0, phase});
      else if (phase < Q3_P) shape = HALF_S - $signed({1'b0, phase});
      else                   shape = $signed({1'b0, phase}) - PERIOD_S;
      product = PW'(active_depth) * PW'(shape);
      scaled  = OFS_W'(product / QTR_S);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= '0;
         active_depth <= NARROW_S;
         offset       <= '0;
      end else begin
         phase  <= run_en ? phase + PH_W'(1) : '0;
         offset <= run_en ? scaled : '0;
         if (!run_en || at_zero) active_depth <= pending_depth;
      end
   end

   assert_idle_offset_zero_R2 : assert property (
      @(posedge clk) disable iff (!rst_n) !run_en |=> (offset == '0));

   assert_offset_in_range_R4 : assert property (
      @(posedge clk) disable iff (!rst_n) (offset <= WIDE_S) && (offset >= -WIDE_S));

   assert_slew_limited_R8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      run_en |=> ((offset - $past(offset)) <= STEP_S) && ((offset - $past(offset)) >= -STEP_S));

   assert_depth_swap_at_zero_R8 : assert property (
      @(posedge clk) disable iff (!rst_n) !$stable(active_depth) |-> (offset == '0));
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
   import ssm_pkg::*;
#(
   parameter int PERIOD      = 1024,
   parameter int OFS_W       = 12,
   parameter int WIDE_PPTT   = 4 * SSM_UNITS_PER_PCT,
   parameter int NARROW_PPTT = 2 * SSM_UNITS_PER_PCT,
   parameter int BLANK_CYC   = 32800,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spread_wide_i,
   input  logic                    run_en_i,
   output logic signed [OFS_W-1:0] freq_offset_o,
   output logic                    blank_o
);
   logic    sel_sync;
   spread_e depth_req;

   ssm_level_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (spread_wide_i),
      .q     (sel_sync)
   );

   assign depth_req = sel_sync ? SPREAD_WIDE : SPREAD_NARROW;

   ssm_blank_timer #(
      .HOLD (BLANK_CYC)
   ) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .level (sel_sync),
      .blank (blank_o)
   );

   ssm_tri_profile #(
      .PERIOD      (PERIOD),
      .OFS_W       (OFS_W),
      .WIDE_PPTT   (WIDE_PPTT),
      .NARROW_PPTT (NARROW_PPTT)
   ) u_profile (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en_i),
      .wide_sel (depth_req == SPREAD_WIDE),
      .offset   (freq_offset_o)
   );
endmodule

// File: tb/test_ssm_profile_gen.sv
`timescale 1ns/1ps
module test_ssm_profile_gen;
   localparam int NBLANK = 32800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0;
   logic run = 1'b0;
   logic signed [11:0] ofs;
   logic blank;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   ssm_profile_gen i_ssm_profile_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .spread_wide_i (sel),
      .run_en_i      (run),
      .freq_offset_o (ofs),
      .blank_o       (blank)
   );

   task automatic tick();
      @(posedge clk);
      #1;
      cyc++;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input int j, input int d);
      int p;
      int t;
      p = j % 1024;
      if (p < 256)      t = p;
      else if (p < 768) t = 512 - p;
      else              t = p - 1024;
      return (d * t) / 256;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      check(ofs == 0, "R1 offset in reset", int'(ofs), 0);
      rst_n = 1'b1;
      repeat (4) tick();
      check(ofs == 0, "R1 offset after reset", int'(ofs), 0);
      check(blank == 1'b0, "R1 blank after reset", int'(blank), 0);
   endtask

   task automatic t_narrow_sweep();
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      int pk = 0;
      int tr = 0;
      run = 1'b1;
      for (int j = 0; j < 1024; j++) begin
         tick();
         if (int'(ofs) != model(j, 200)) begin
            if (bad == 0) begin first_act = int'(ofs); first_exp = model(j, 200); end
            bad++;
         end
         if (j == 256) pk = int'(ofs);
         if (j == 768) tr = int'(ofs);
      end
      check(bad == 0, "R3 narrow profile", first_act, first_exp);
      check(pk == 200, "R4 narrow positive peak", pk, 200);
      check(tr == -200, "R4 narrow negative peak", tr, -200);
      check(pk >= 180 && pk <= 220, "R4 narrow peak window", pk, 200);
   endtask

   task automatic t_disable_restart();
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      for (int j = 0; j < 100; j++) tick();
      run = 1'b0;
      tick();
      check(ofs == 0, "R2 offset zero when disabled", int'(ofs), 0);
      for (int j = 0; j < 3; j++) begin
         tick();
         if (ofs != 0) bad++;
      end
      check(bad == 0, "R2 offset held zero", bad, 0);
      bad = 0;
      run = 1'b1;
      for (int j = 0; j < 300; j++) begin
         tick();
         if (int'(ofs) != model(j, 200)) begin
            if (bad == 0) begin first_act = int'(ofs); first_exp = model(j, 200); end
            bad++;
         end
      end
      check(bad == 0, "R2 restart from phase start", first_act, first_exp);
   endtask

   task automatic t_depth_change();
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      int slew_bad = 0;
      int prev = 0;
      int b101 = 0;
      int b102 = 0;
      int v512 = 0;
      int v768 = 0;
      int bcount = 0;
      int guard = 0;
      int d;
      run = 1'b0;
      tick();
      tick();
      run = 1'b1;
      for (int j = 0; j <= 1300; j++) begin
         tick();
         d = (j <= 512) ? 200 : 400;
         if (int'(ofs) != model(j, d)) begin
            if (bad == 0) begin first_act = int'(ofs); first_exp = model(j, d); end
            bad++;
         end
         if (j > 0 && ((int'(ofs) - prev) > 2 || (int'(ofs) - prev) < -2)) slew_bad++;
         prev = int'(ofs);
         if (j == 101) b101 = int'(blank);
         if (j == 102) b102 = int'(blank);
         if (j == 512) v512 = int'(ofs);
         if (j == 768) v768 = int'(ofs);
         if (blank) bcount++;
         if (j == 99) sel = 1'b1;
      end
      check(b101 == 0, "R5 blank not yet raised", b101, 0);
      check(b102 == 1, "R5 blank on third edge", b102, 1);
      check(bad == 0, "R8 depth taken at zero crossing", first_act, first_exp);
      check(v512 == 0, "R8 zero at crossing", v512, 0);
      check(v768 == -400, "R8 wide trough after swap", v768, -400);
      check(slew_bad == 0, "R8 slew limit", slew_bad, 0);
      while (blank && guard < 40000) begin
         tick();
         guard++;
         if (blank) bcount++;
      end
      check(bcount == NBLANK, "R6 blank length", bcount, NBLANK);
   endtask

   task automatic t_blank_restart();
      int c1;
      int cnt = 0;
      int guard = 0;
      int ofs_bad = 0;
      run = 1'b0;
      tick();
      sel = 1'b0;
      c1 = cyc;
      while (cyc < c1 + 1000) begin
         tick();
         if (blank) cnt++;
         if (ofs != 0) ofs_bad++;
         if (cyc == c1 + 2) check(blank == 1'b0, "R5 blank low before sync", int'(blank), 0);
         if (cyc == c1 + 3) check(blank == 1'b1, "R5 blank raised after sync", int'(blank), 1);
      end
      sel = 1'b1;
      do begin
         tick();
         guard++;
         if (blank) cnt++;
         if (ofs != 0) ofs_bad++;
      end while (blank && guard < 40000);
      check(cnt == 1000 + NBLANK, "R7 blank restarted by second change", cnt, 1000 + NBLANK);
      check(ofs_bad == 0, "R9 blanking while disabled keeps offset zero", ofs_bad, 0);
   endtask

   task automatic t_wide_idle_take();
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      int pk = 0;
      int tr = 0;
      int bl = 0;
      run = 1'b1;
      for (int j = 0; j <= 800; j++) begin
         tick();
         if (int'(ofs) != model(j, 400)) begin
            if (bad == 0) begin first_act = int'(ofs); first_exp = model(j, 400); end
            bad++;
         end
         if (j == 256) pk = int'(ofs);
         if (j == 768) tr = int'(ofs);
         if (blank) bl++;
      end
      check(bad == 0, "R9 depth adopted while idle", first_act, first_exp);
      check(pk == 400, "R4 wide positive peak", pk, 400);
      check(tr == -400, "R4 wide negative peak", tr, -400);
      check(pk >= 360 && pk <= 440, "R4 wide peak window", pk, 400);
      check(bl == 0, "R6 no blank without change", bl, 0);
   endtask

   initial begin
      t_reset();
      t_narrow_sweep();
      t_disable_restart();
      t_depth_change();
      t_blank_restart();
      t_wide_idle_take();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule